// File: doc/BRIEF.md
# Channel Address Hold and Bank Select Decoder

This block is the digital control section in front of a sixteen-input analog multiplexer. A four-bit channel code goes into a level-sensitive hold register. While the open input is high the code passes straight through. When the open input drops, the last code seen stays in the register. The decoder turns the code into one-hot enables for two banks of eight analog switches. The first bank carries inputs 0 to 7. The second bank carries inputs 8 to 15, and these same lines serve as the return inputs of the pairs.

A mode input chooses how the held code is read. In single mode the four bits name one of sixteen inputs. In pair mode the lower three bits name one of eight pairs. Switch n of both banks then closes together, and the top code bit must be 1 as a pair enable. A pair-mode code with the top bit at 0 closes nothing and raises a flag. The mode is not stored, so it can be changed while a code is held and the same code is read again at once. The register is modelled on a clock. It takes the code at every rising edge where the open input is high. A synchronous reset clears it to code 0.

Top module: `chan_mux_ctl`

## Requirements
- R1: After a synchronous reset, with `latch_en` low and `diff_mode` 0, the held code is 0: `hi_sel` = 8'b0000_0001, `lo_sel` = 0 and `invalid` = 0, whatever `chan_addr` carries.
- R2: While `latch_en` is 1 the selects follow `chan_addr` in the same cycle, with no clock edge in between.
- R3: While `latch_en` is 0 the selects reflect the code present at the last rising clock edge at which `latch_en` was 1. Changes on `chan_addr` have no effect.
- R4: In single mode (`diff_mode` = 0), a code c from 0 to 7, with bit 3 at 0, sets `hi_sel` bit c only, and `lo_sel` is 0.
- R5: In single mode, a code c from 8 to 15, with bit 3 at 1, sets `lo_sel` bit c-8 only, and `hi_sel` is 0.
- R6: In pair mode (`diff_mode` = 1), with code bit 3 at 1, code bits 2:0 give a pair index n. Both `hi_sel` bit n and `lo_sel` bit n are set, nothing else is set, and `invalid` is 0.
- R7: In pair mode with code bit 3 at 0, `hi_sel` and `lo_sel` are all zero and `invalid` is 1.
- R8: Each bank select is one-hot or zero. `invalid` is never 1 in single mode.
- R9: `diff_mode` is not stored. Changing it while a code is held reinterprets that held code in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; clears the held code to 0 |
| latch_en | input | 1 | 1: code passes through and is taken at each edge; 0: code held |
| chan_addr | input | 4 | Channel code; bit 3 is the extension/pair-enable bit |
| diff_mode | input | 1 | 0: single mode, 16 inputs; 1: pair mode, 8 pairs |
| hi_sel | output | 8 | One-hot enables of the first switch bank (inputs 0 to 7) |
| lo_sel | output | 8 | One-hot enables of the second switch bank (inputs 8 to 15 or pair returns) |
| invalid | output | 1 | Pair mode with the pair enable bit clear |

## Verification
The first group of stimulus drives the block with the register open, covering codes on both sides of the bank boundary. This shows the boundary decision and the index taken off by 8 for the second bank. A second group closes the register and then moves the code. This tells a true hold apart from a pass-through or a capture one cycle late. A third group flips the mode on a held code and runs pair-mode codes with the enable bit set and clear. These show that the mode is applied live, that both banks close at the same index, and that the disabled case stays dark. A reset in the middle of the run, taken after a non-zero code, confirms that the held value goes back to code 0.

// File: rtl/chan_mux_pkg.sv
package chan_mux_pkg;

    // Reading of the held channel code
    typedef enum logic {
        RD_SINGLE = 1'b0,
        RD_PAIR   = 1'b1
    } read_mode_e;

endpackage

// File: rtl/chan_hold.sv
// Level-sensitive channel code register modelled on the clock:
// open -> pass-through and capture each edge, closed -> last captured code.
module chan_hold #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          open_en,
    input  logic [AW-1:0] code_in,
    output logic [AW-1:0] code_out
);

    logic [AW-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (open_en) begin
            held_q <= code_in;
        end
    end

    always_comb begin
        code_out = open_en ? code_in : held_q;
    end

endmodule

// File: rtl/bank_decode.sv
// Turns the effective code into enables for the two switch banks.
module bank_decode
    import chan_mux_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic [SEL_W:0]         code,
    input  read_mode_e             mode,
    output logic [(1<<SEL_W)-1:0]  hi_sel,
    output logic [(1<<SEL_W)-1:0]  lo_sel,
    output logic                   invalid
);

    localparam int NPAIR = 1 << SEL_W;
    localparam int AW    = SEL_W + 1;

    logic             is_single;
    logic             pair_on;
    logic [SEL_W-1:0] idx;

    always_comb begin
        is_single = (mode == RD_SINGLE);
        idx       = code[SEL_W-1:0];
        pair_on   = (mode == RD_PAIR) && code[SEL_W];
        invalid   = (mode == RD_PAIR) && !code[SEL_W];
    end

    for (genvar i = 0; i < NPAIR; i++) begin : g_line
        assign hi_sel[i] = (is_single && (code == AW'(i)))
                         || (pair_on && (idx == SEL_W'(i)));
        assign lo_sel[i] = (is_single && (code == AW'(i + NPAIR)))
                         || (pair_on && (idx == SEL_W'(i)));
    end

endmodule

// File: rtl/chan_mux_ctl.sv
module chan_mux_ctl
    import chan_mux_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  latch_en,
    input  logic [SEL_W:0]        chan_addr,
    input  logic                  diff_mode,
    output logic [(1<<SEL_W)-1:0] hi_sel,
    output logic [(1<<SEL_W)-1:0] lo_sel,
    output logic                  invalid
);

    localparam int AW = SEL_W + 1;

    logic [AW-1:0] eff_code;
    read_mode_e    rd_mode;

    always_comb begin
        rd_mode = diff_mode ? RD_PAIR : RD_SINGLE;
    end

    chan_hold #(.AW(AW)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .open_en  (latch_en),
        .code_in  (chan_addr),
        .code_out (eff_code)
    );

    bank_decode #(.SEL_W(SEL_W)) u_dec (
        .code    (eff_code),
        .mode    (rd_mode),
        .hi_sel  (hi_sel),
        .lo_sel  (lo_sel),
        .invalid (invalid)
    );

endmodule

// File: rtl/chan_mux_ctl_chk.sv
module chan_mux_ctl_chk #(
    parameter int SEL_W = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  latch_en,
    input logic [SEL_W:0]        chan_addr,
    input logic                  diff_mode,
    input logic [(1<<SEL_W)-1:0] hi_sel,
    input logic [(1<<SEL_W)-1:0] lo_sel,
    input logic                  invalid
);

    logic armed_q;

    always_ff @(posedge clk) begin
        armed_q <= !rst;
    end

    AST_HI_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hi_sel)); // R8
    AST_LO_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lo_sel)); // R8
    AST_SINGLE_ONE_LINE: assert property (@(posedge clk) disable iff (rst)
        !diff_mode |-> ($countones({hi_sel, lo_sel}) == 1 && !invalid)); // R4
    AST_PAIR_MATCHED: assert property (@(posedge clk) disable iff (rst)
        (diff_mode && !invalid) |-> (hi_sel == lo_sel && $countones(hi_sel) == 1)); // R6
    AST_INVALID_DARK: assert property (@(posedge clk) disable iff (rst)
        invalid |-> (hi_sel == '0 && lo_sel == '0 && diff_mode)); // R7
    AST_OPEN_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (latch_en && !diff_mode && !chan_addr[SEL_W])
            |-> hi_sel[chan_addr[SEL_W-1:0]]); // R2
    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !latch_en && !$past(latch_en) && diff_mode == $past(diff_mode))
            |-> $stable({hi_sel, lo_sel, invalid})); // R3

endmodule

bind chan_mux_ctl chan_mux_ctl_chk #(.SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .latch_en  (latch_en),
    .chan_addr (chan_addr),
    .diff_mode (diff_mode),
    .hi_sel    (hi_sel),
    .lo_sel    (lo_sel),
    .invalid   (invalid)
);

// File: tb/sim_chan_mux_ctl.sv
module sim_chan_mux_ctl;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       latch_en = 1'b0;
    logic [3:0] chan_addr = 4'd0;
    logic       diff_mode = 1'b0;
    logic [7:0] hi_sel;
    logic [7:0] lo_sel;
    logic       invalid;

    typedef struct {
        logic [7:0] hi;
        logic [7:0] lo;
        logic       inv;
        string      tag;
    } item_t;

    item_t exp_q[$];
    int    n_run  = 0;
    int    n_fail = 0;
    logic  [3:0] ref_held = 4'd0;
    bit    done = 1'b0;
    event  ev_chk;

    always #(CLK_P/2) clk = ~clk;

    chan_mux_ctl u0 (
        .clk       (clk),
        .rst       (rst),
        .latch_en  (latch_en),
        .chan_addr (chan_addr),
        .diff_mode (diff_mode),
        .hi_sel    (hi_sel),
        .lo_sel    (lo_sel),
        .invalid   (invalid)
    );

    // Expected selects, written from the requirements
    function automatic item_t expect_of(logic [3:0] c, logic m, string tag);
        item_t it;
        it.hi = '0; it.lo = '0; it.inv = 1'b0; it.tag = tag;
        if (!m) begin
            if (!c[3]) it.hi[c[2:0]] = 1'b1;   // R4
            else       it.lo[c[2:0]] = 1'b1;   // R5
        end else begin
            if (c[3]) begin                    // R6
                it.hi[c[2:0]] = 1'b1;
                it.lo[c[2:0]] = 1'b1;
            end else begin
                it.inv = 1'b1;                 // R7
            end
        end
        return it;
    endfunction

    task automatic step(input logic le, input logic [3:0] a, input logic m, input string tag);
        logic [3:0] eff;
        @(negedge clk);
        latch_en  = le;
        chan_addr = a;
        diff_mode = m;
        eff = le ? a : ref_held;
        exp_q.push_back(expect_of(eff, m, tag));
        #2;
        -> ev_chk;
        if (le) ref_held = a;   // taken at the coming rising edge
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst = 1'b1;
        latch_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        ref_held = 4'd0;
    endtask

    // Monitor: pops and compares
    initial begin
        forever begin
            @(ev_chk);
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                n_run++;
                if (hi_sel !== it.hi || lo_sel !== it.lo || invalid !== it.inv) begin
                    n_fail++;
                    $display("FAIL %s: got hi=%b lo=%b inv=%b, expected hi=%b lo=%b inv=%b",
                             it.tag, hi_sel, lo_sel, invalid, it.hi, it.lo, it.inv);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step(1'b0, 4'd9,  1'b0, "R1 reset holds code 0");
        step(1'b1, 4'd5,  1'b0, "R2 open code 5");
        step(1'b1, 4'd3,  1'b0, "R2 R4 open code 3");
        step(1'b1, 4'd0,  1'b0, "R4 code 0");
        step(1'b1, 4'd7,  1'b0, "R4 code 7 bank edge");
        step(1'b1, 4'd8,  1'b0, "R5 code 8 bank edge");
        step(1'b1, 4'd15, 1'b0, "R5 code 15");
        step(1'b1, 4'd12, 1'b0, "R5 R8 code 12");
        step(1'b0, 4'd2,  1'b0, "R3 closed ignores code 2");
        step(1'b0, 4'd7,  1'b0, "R3 closed ignores code 7");
        step(1'b0, 4'd1,  1'b1, "R9 held 12 read as pair 4");
        step(1'b0, 4'd1,  1'b0, "R9 back to single");
        step(1'b1, 4'd14, 1'b1, "R6 pair 6");
        step(1'b0, 4'd3,  1'b0, "R3 R9 held 14 single");
        step(1'b1, 4'd5,  1'b1, "R7 pair enable clear");
        step(1'b0, 4'd9,  1'b1, "R7 held invalid");
        step(1'b1, 4'd13, 1'b1, "R6 pair 5");
        step(1'b1, 4'd8,  1'b1, "R6 pair 0");
        step(1'b1, 4'd11, 1'b0, "R5 code 11 before reset");
        pulse_reset();
        step(1'b0, 4'd6,  1'b0, "R1 reset mid-run clears code");
        step(1'b0, 4'd6,  1'b1, "R1 R7 cleared code in pair mode");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule